// File: doc/BRIEF.md
# Dual-Output Timer Waveform Generator

This block is a single timer channel that produces two pulse-width-modulated outputs sharing one period. A 16-bit up-counter advances on ticks from a selectable clock source. It returns to zero when it equals a period register, so both outputs run on the same period. Each output has its own duty register. Each output also has four programmable action fields, one for each of four events: software trigger, external event, period match and duty match. Each field decides whether its event leaves the output alone, sets it, clears it or toggles it.

Software programs the channel through a small synchronous register port and starts it with a command write. That write enables the clock and fires the software trigger. Normal polarity clears an output on its duty match and sets it on the period match. Inverted polarity swaps those two actions. For a constant level, no match actions are programmed, and the software-trigger action alone fixes the output.

Top module: `tmr_wavegen`

## Requirements
- R1: After reset both outputs are low, the counter reads 0, the clock is stopped, and the mode, duty and period registers read 0.
- R2: While the clock runs, each tick of the selected source increments the counter. On a tick where the counter equals the period register, the counter returns to 0 instead, giving a period of period+1 ticks.
- R3: Mode bits [2:0] select the tick source. Values 0 to 4 pick `tick_src[0]` to `tick_src[4]`. Values 5 to 7 select no source, so the counter never advances.
- R4: A command write (address 1) with bit 0 set starts the clock, and one with bit 1 set stops it. If both bits are set, the stop wins. A stopped counter holds its value and produces no match events.
- R5: A command write with bit 2 set is the software trigger. It loads the counter with 0 at that edge and applies each output's software-trigger action.
- R6: An output with software-trigger set, period-match set and duty-match clear is high while the counter is at most its duty value. It is low for the rest of the period. Matches take effect at the clock edge of the tick on which the counter equals the register.
- R7: With software-trigger clear, period-match clear and duty-match set (inverted polarity), the output is low while the counter is at most its duty value and high otherwise.
- R8: With no match actions programmed, the output keeps the level set by the last software trigger for any number of periods.
- R9: When events coincide in one cycle, only one of them acts on each output. The order from highest to lowest is software trigger, external event, period match, duty match.
- R10: Action fields are 2 bits: 0 none, 1 set, 2 clear, 3 toggle. Mode bits [10:3] belong to output A and bits [18:11] to output B. Within each byte the order from low to high is duty match, period match, external event, software trigger.
- R11: Writes to address 0 (mode, 19 bits), 2 (duty A), 3 (duty B) and 4 (period) read back unchanged on `rd_data` at the same address. Address 5 reads the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_src | input | 5 | Tick enables of the five clock sources |
| ext_evt | input | 1 | External event, one pulse per cycle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 19 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 19 | Read data, combinational |
| out_a | output | 1 | Waveform output A |
| out_b | output | 1 | Waveform output B |

## Verification
The assertions assume that the tick inputs, the external event and the write strobe are synchronous levels that are known at every rising edge. They also assume that a command write is a single cycle, so that a software trigger lasts exactly one edge. The stimulus drives every input at the falling edge from known values, holds each write or event pulse for one cycle only, and stops the clock before it reprograms the registers. This keeps stray matches from appearing during reconfiguration.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int SEL_W = 3;
    localparam int REG_W = 19;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TOG  = 2'd3
    } act_t;

    // one byte of actions per output, lowest field first: duty, period, ext, sw
    typedef struct packed {
        act_t on_sw;
        act_t on_ext;
        act_t on_per;
        act_t on_duty;
    } out_cfg_t;

    typedef struct packed {
        out_cfg_t          b;
        out_cfg_t          a;
        logic [SEL_W-1:0]  src;
    } mode_t;

    localparam logic [2:0] ADR_MODE = 3'd0;
    localparam logic [2:0] ADR_CMD  = 3'd1;
    localparam logic [2:0] ADR_DA   = 3'd2;
    localparam logic [2:0] ADR_DB   = 3'd3;
    localparam logic [2:0] ADR_PER  = 3'd4;
    localparam logic [2:0] ADR_CNT  = 3'd5;

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel #(
    parameter int NUM_SRC = 5
) (
    input  logic [NUM_SRC-1:0]       tick_src,
    input  logic [tmr_pkg::SEL_W-1:0] sel,
    output logic                      tick
);
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel == tmr_pkg::SEL_W'(i)) tick = tick_src[i];
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             sw_trig,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] cnt,
    output logic             per_hit
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        per_hit = tick_en && (cnt_q == period);
        cnt_d   = cnt_q;
        if (sw_trig)      cnt_d = '0;
        else if (per_hit) cnt_d = '0;
        else if (tick_en) cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && cnt_q == period) |=> (cnt_q == '0));
    a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !sw_trig) |=> $stable(cnt_q));
    a_r5_trigger_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        sw_trig |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_out_act.sv
module tmr_out_act #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_pkg::out_cfg_t cfg,
    input  logic              sw_trig,
    input  logic              ext_evt,
    input  logic              per_hit,
    input  logic              tick_en,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [CNT_W-1:0]  duty,
    output logic              wave
);
    import tmr_pkg::*;

    logic out_d, out_q;
    logic duty_hit;
    act_t act;

    always_comb begin
        duty_hit = tick_en && (cnt == duty);
        if (sw_trig)       act = cfg.on_sw;
        else if (ext_evt)  act = cfg.on_ext;
        else if (per_hit)  act = cfg.on_per;
        else if (duty_hit) act = cfg.on_duty;
        else               act = ACT_NONE;
        unique case (act)
            ACT_SET: out_d = 1'b1;
            ACT_CLR: out_d = 1'b0;
            ACT_TOG: out_d = !out_q;
            default: out_d = out_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign wave = out_q;

    a_r9_trigger_first: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_trig && cfg.on_sw == ACT_SET) |=> out_q);
    a_r9_ext_over_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_trig && ext_evt && cfg.on_ext == ACT_CLR) |=> !out_q);
    a_r10_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!sw_trig && !ext_evt && !tick_en) |=> $stable(out_q));
endmodule

// File: rtl/tmr_wavegen.sv
module tmr_wavegen #(
    parameter int CNT_W   = 16,
    parameter int NUM_SRC = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        tick_src,
    input  logic                      ext_evt,
    input  logic                      wr_en,
    input  logic [2:0]                wr_addr,
    input  logic [tmr_pkg::REG_W-1:0] wr_data,
    input  logic [2:0]                rd_addr,
    output logic [tmr_pkg::REG_W-1:0] rd_data,
    output logic                      out_a,
    output logic                      out_b
);
    import tmr_pkg::*;

    localparam int MODE_W = $bits(mode_t);
    localparam int PAD_W  = REG_W - CNT_W;

    typedef struct packed {
        mode_t            mode;
        logic [CNT_W-1:0] duty_a;
        logic [CNT_W-1:0] duty_b;
        logic [CNT_W-1:0] period;
        logic             run;
    } state_t;

    state_t st_d, st_q;
    logic cmd_wr, go, halt, sw_trig;
    logic tick, tick_en, per_hit;
    logic [CNT_W-1:0] cnt;
    logic [1:0] wave;

    always_comb begin
        st_d    = st_q;
        cmd_wr  = wr_en && (wr_addr == ADR_CMD);
        go      = cmd_wr && wr_data[0];
        halt    = cmd_wr && wr_data[1];
        sw_trig = cmd_wr && wr_data[2];
        if (wr_en) begin
            case (wr_addr)
                ADR_MODE: st_d.mode   = mode_t'(wr_data[MODE_W-1:0]);
                ADR_DA:   st_d.duty_a = wr_data[CNT_W-1:0];
                ADR_DB:   st_d.duty_b = wr_data[CNT_W-1:0];
                ADR_PER:  st_d.period = wr_data[CNT_W-1:0];
                default:  ;
            endcase
        end
        if (go)   st_d.run = 1'b1;
        if (halt) st_d.run = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (rd_addr)
            ADR_MODE: rd_data = st_q.mode;
            ADR_DA:   rd_data = {{PAD_W{1'b0}}, st_q.duty_a};
            ADR_DB:   rd_data = {{PAD_W{1'b0}}, st_q.duty_b};
            ADR_PER:  rd_data = {{PAD_W{1'b0}}, st_q.period};
            ADR_CNT:  rd_data = {{PAD_W{1'b0}}, cnt};
            default:  rd_data = '0;
        endcase
    end

    tmr_src_sel #(.NUM_SRC(NUM_SRC)) i_sel (
        .tick_src(tick_src), .sel(st_q.mode.src), .tick(tick)
    );

    assign tick_en = st_q.run && tick;

    tmr_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sw_trig(sw_trig),
        .period(st_q.period), .cnt(cnt), .per_hit(per_hit)
    );

    for (genvar g = 0; g < 2; g++) begin : g_out
        tmr_out_act #(.CNT_W(CNT_W)) i_act (
            .clk(clk), .rst_n(rst_n),
            .cfg((g == 0) ? st_q.mode.a : st_q.mode.b),
            .sw_trig(sw_trig), .ext_evt(ext_evt), .per_hit(per_hit),
            .tick_en(tick_en), .cnt(cnt),
            .duty((g == 0) ? st_q.duty_a : st_q.duty_b),
            .wave(wave[g])
        );
    end

    assign out_a = wave[0];
    assign out_b = wave[1];

    a_r4_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !st_q.run);
    a_r4_stopped_no_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !sw_trig) |=> $stable(cnt));
endmodule

// File: tb/test_tmr_wavegen.sv
module test_tmr_wavegen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  tick_src = '0;
    logic        ext_evt = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [18:0] wr_data = '0;
    logic [2:0]  rd_addr = 3'd5;
    logic [18:0] rd_data;
    logic        out_a, out_b;

    always #4 clk = ~clk;

    tmr_wavegen i_tmr_wavegen (
        .clk(clk), .rst_n(rst_n), .tick_src(tick_src), .ext_evt(ext_evt),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .out_a(out_a), .out_b(out_b)
    );

    localparam logic [1:0] NO = 2'd0, ST = 2'd1, CL = 2'd2, TG = 2'd3;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int m_cnt = 0, m_per = 0, m_sel = 0;
    bit m_run = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] acts(input logic [1:0] sw, input logic [1:0] ex,
                                        input logic [1:0] pe, input logic [1:0] du);
        return {sw, ex, pe, du};
    endfunction

    // one clock: drive ticks, let the edge pass, update the arithmetic model
    task automatic step();
        bit sw, go, halt, ten;
        for (int k = 0; k < 5; k++) tick_src[k] = ((cyc % (1 << k)) == 0);
        @(posedge clk);
        sw   = wr_en && wr_addr == 3'd1 && wr_data[2];
        go   = wr_en && wr_addr == 3'd1 && wr_data[0];
        halt = wr_en && wr_addr == 3'd1 && wr_data[1];
        ten  = m_run && (m_sel < 5) && tick_src[m_sel];
        if (sw) m_cnt = 0;
        else if (ten) m_cnt = (m_cnt == m_per) ? 0 : m_cnt + 1;
        if (go) m_run = 1;
        if (halt) m_run = 0;
        if (wr_en && wr_addr == 3'd0) m_sel = int'(wr_data[2:0]);
        if (wr_en && wr_addr == 3'd4) m_per = int'(wr_data[15:0]);
        cyc++;
        @(negedge clk);
        wr_en = 1'b0;
        ext_evt = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [18:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
    endtask

    task automatic setup(input int sel, input logic [7:0] ca, input logic [7:0] cb,
                         input int da, input int db, input int per);
        wr(3'd1, 19'd2);
        wr(3'd0, {3'b0, cb, ca, 3'(sel)});
        wr(3'd2, 19'(da));
        wr(3'd3, 19'(db));
        wr(3'd4, 19'(per));
        wr(3'd1, 19'd5);
    endtask

    task automatic chk_cnt(input string req);
        chk(int'(rd_data) == m_cnt, req, int'(rd_data), m_cnt);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired");
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int pers[3] = '{3, 5, 9};
        int held;
        logic v;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(out_a == 0 && out_b == 0, "R1 outputs", {out_a, out_b}, 0);
        chk_cnt("R1 counter");
        for (int a = 0; a < 5; a++) begin
            rd_addr = 3'(a); #1;
            chk(rd_data == 0, "R1 registers", int'(rd_data), 0);
        end
        rd_addr = 3'd5;
        step(); step();
        chk_cnt("R4 stopped after reset");

        // R6/R7/R2 duty sweep, A normal, B inverted
        foreach (pers[i]) begin
            for (int d = 1; d < pers[i]; d++) begin
                int db = pers[i] - d;
                setup(0, acts(ST, NO, ST, CL), acts(CL, NO, CL, ST), d, db, pers[i]);
                chk(int'(rd_data) == 0, "R5 trigger zeroes counter", int'(rd_data), 0);
                chk(out_a == 1 && out_b == 0, "R5 trigger actions", {out_a, out_b}, 2);
                for (int n = 0; n < 2 * (pers[i] + 1) + 2; n++) begin
                    step();
                    chk_cnt("R2 counter wrap");
                    chk(out_a == (m_cnt <= d), "R6 normal output", out_a, m_cnt <= d);
                    chk(out_b == (m_cnt > db), "R7 inverted output", out_b, m_cnt > db);
                end
            end
        end

        // R3 source selection
        for (int s = 1; s < 8; s++) begin
            setup(s, acts(ST, NO, ST, CL), acts(NO, NO, NO, NO), 1, 0, 3);
            for (int n = 0; n < 40; n++) begin
                step();
                chk_cnt("R3 source tick");
                chk(out_a == (m_cnt <= 1), "R3 output on slow tick", out_a, m_cnt <= 1);
                if (s >= 5) chk(int'(rd_data) == 0, "R3 no source", int'(rd_data), 0);
            end
        end

        // R4 enable/disable, stop wins
        setup(0, acts(NO, NO, NO, NO), acts(NO, NO, NO, NO), 0, 0, 200);
        repeat (7) step();
        wr(3'd1, 19'd3);
        held = int'(rd_data);
        repeat (6) step();
        chk(int'(rd_data) == held, "R4 stop wins over start", int'(rd_data), held);
        wr(3'd1, 19'd1);
        repeat (4) step();
        chk(int'(rd_data) == held + 4, "R4 restart resumes", int'(rd_data), held + 4);
        // R5 trigger mid-count
        wr(3'd1, 19'd4);
        chk(int'(rd_data) == 0, "R5 mid-count trigger", int'(rd_data), 0);
        step();
        chk_cnt("R5 counts after trigger");

        // R8 constant levels
        setup(0, acts(CL, NO, NO, NO), acts(ST, NO, NO, NO), 0, 4, 4);
        for (int n = 0; n < 16; n++) begin
            step();
            chk(out_a == 0, "R8 zero duty stays low", out_a, 0);
            chk(out_b == 1, "R8 full duty stays high", out_b, 1);
        end

        // R9 external event beats period match
        setup(0, acts(ST, CL, ST, NO), acts(NO, NO, NO, NO), 0, 0, 4);
        while (m_cnt != 4) step();
        ext_evt = 1'b1;
        step();
        chk(out_a == 0, "R9 ext over period", out_a, 0);
        chk(int'(rd_data) == 0, "R9 period still wraps", int'(rd_data), 0);
        // R9 period match beats duty match
        setup(0, acts(CL, NO, ST, CL), acts(NO, NO, NO, NO), 4, 0, 4);
        chk(out_a == 0, "R9 start low", out_a, 0);
        while (m_cnt != 4) step();
        step();
        chk(out_a == 1, "R9 period over duty", out_a, 1);
        // R9 trigger beats external event
        setup(0, acts(CL, NO, NO, NO), acts(NO, NO, NO, NO), 0, 0, 4);
        wr(3'd0, {3'b0, acts(NO, NO, NO, NO), acts(ST, CL, NO, NO), 3'd0});
        ext_evt = 1'b1;
        wr(3'd1, 19'd4);
        chk(out_a == 1, "R9 trigger over ext", out_a, 1);

        // R10 encodings through the external event
        wr(3'd1, 19'd2);
        wr(3'd0, {3'b0, acts(NO, TG, NO, NO), acts(NO, NO, NO, NO), 3'd0});
        v = out_b;
        for (int n = 0; n < 3; n++) begin
            ext_evt = 1'b1; step();
            v = !v;
            chk(out_b == v, "R10 toggle", out_b, v);
            chk(out_a == 1, "R10 none keeps level", out_a, 1);
        end
        wr(3'd0, {3'b0, acts(NO, ST, NO, NO), acts(NO, CL, NO, NO), 3'd0});
        ext_evt = 1'b1; step();
        chk(out_a == 0 && out_b == 1, "R10 set and clear", {out_a, out_b}, 1);

        // R11 readback
        wr(3'd0, 19'h7FFFF);
        wr(3'd2, 19'h0A5C3);
        wr(3'd3, 19'h0FFFF);
        wr(3'd4, 19'h01234);
        rd_addr = 3'd0; #1; chk(rd_data == 19'h7FFFF, "R11 mode", int'(rd_data), 'h7FFFF);
        rd_addr = 3'd2; #1; chk(rd_data == 19'h0A5C3, "R11 duty A", int'(rd_data), 'hA5C3);
        rd_addr = 3'd3; #1; chk(rd_data == 19'h0FFFF, "R11 duty B", int'(rd_data), 'hFFFF);
        rd_addr = 3'd4; #1; chk(rd_data == 19'h01234, "R11 period", int'(rd_data), 'h1234);

        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule